// File: doc/BRIEF.md
# BCD Clock-Calendar Counter with Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours in 24-hour form, weekday, day of month, month, a two-digit year and a century bit that flips each time the year wraps. A single-cycle strobe at 64 Hz feeds a 6-stage prescaler. The prescaler makes a one-second tick, and the tick ripples through the count chain. Month lengths follow the calendar. February gets a 29th day whenever the two-digit year is a multiple of four.

A halt control freezes the chain and parks the prescaler at zero, so the first second after release lands half a second later. Software can use this to line up the second boundary with an outside event. A sticky oscillator-fail flag sits in the top bit of the seconds register. An alarm comparator watches minute, hour, date and weekday. Each of those fields has its own active-low enable. The alarm raises a sticky flag, and that flag, gated by an enable, drives an interrupt output.

The host side is a plain register port. A write strobe with address and data is accepted in every cycle: there is no back-pressure and no ready signal. The read data is a combinational function of the read address, so the port has no valid/ready handshake.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 0x00..0x59 and hours count 0x00..0x23 in BCD. Each field returns to 0x00 after its top value and carries one into the next field in the same tick. Register map: 1 = seconds, 2 = minutes, 3 = hours.
- R2: The weekday (address 4) counts 0..6 and wraps to 0. It advances in the same tick as the date, when the hours wrap.
- R3: The date (address 5, BCD, 0x01..) ends at 0x31, 0x30, 0x29 or 0x28 according to the month. February (0x02) ends at 0x29 exactly when the BCD year's value is a multiple of 4. After its last day the date becomes 0x01 and the month advances.
- R4: The month (address 6, bits 4:0) counts 0x01..0x12 and carries into the year (address 7), which counts 0x00..0x99. Bit 7 of address 6 is the century bit, and it toggles when the year goes from 0x99 to 0x00.
- R5: The prescaler produces one tick for every 64 strobes. Control register (address 0) bit 0 is halt. While halt is 1, the prescaler is held at zero and no time field advances.
- R6: After halt returns to 0, the first tick happens on the 32nd strobe, and every later tick happens on every 64th strobe.
- R7: Seconds bit 7 is the oscillator-fail flag. It reads 1 after reset and is set by `osc_fail_i`. Only a seconds write with bit 7 = 0 clears it.
- R8: Alarm registers are at addresses 8 (minute), 9 (hour), 10 (date) and 11 (weekday). A field takes part in the comparison only when its bit 7 is 0. The alarm flag (control bit 2) sets when all enabled fields start to match the time. With no field enabled it never sets.
- R9: A control write with bit 2 = 0 clears the alarm flag, and a write with bit 2 = 1 leaves the flag unchanged. After a clear, the flag sets again only on a new transition into a match.
- R10: `alarm_irq_o` is high exactly when the alarm flag and control bit 1 (alarm interrupt enable) are both 1.
- R11: A host write to any time field (addresses 1..7) wins over a tick in the same cycle. That tick is dropped, and every field keeps its value except the one written.
- R12: Reset values: control 0x00, seconds 0x80, date 0x01, month 0x01, other time fields 0x00, alarm registers 0x80. Addresses 12..15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick64_i | input | 1 | One-cycle 64 Hz strobe |
| osc_fail_i | input | 1 | Oscillator failure indication |
| wr_en_i | input | 1 | Host write strobe, accepted every cycle |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 4 | Host read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt, active high |

## Verification
A wrong prescaler phase is seen at the first second after halt is released: the seconds register moves one strobe early or late. A wrong carry or month-length decision shows up in the very tick that crosses the boundary, as a wrong date, month, year or century value read right after that tick. A wrong alarm edge detector shows up one cycle after the matching tick, either as a flag that never rises or as one that comes back after a clear while the time still matches.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_WDAY  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MONTH = 4'd6;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'd9;
  localparam logic [ADDR_W-1:0] A_ADATE = 4'd10;
  localparam logic [ADDR_W-1:0] A_AWDAY = 4'd11;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
    logic       century;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Last BCD date of a month; leap test uses 10 == 2 (mod 4)
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [5:0] r;
    logic [7:0] d;
    r = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    case (mon)
      8'h02:                      d = (r[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic halt_i,
  output logic tick_o
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST    = PW'(DIV - 1);
  localparam logic [PW-1:0] FIRE_AT = PW'(DIV / 2 - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || halt_i) cnt <= '0;
    else if (strobe_i)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick_o = strobe_i && !halt_i && (cnt == FIRE_AT);

  a_r5_halt_parks: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (cnt == '0));
  a_r5_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |-> !tick_o);
  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !halt_i) |=> $stable(cnt));
endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              osc_fail_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output rtc_time_t         time_o,
  output logic              osf_o
);
  rtc_time_t t, nxt;
  logic time_wr;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;

  assign time_wr = wr_en_i && (wr_addr_i >= A_SEC) && (wr_addr_i <= A_YEAR);

  always_comb begin
    sec_wrap  = (t.sec == 8'h59);
    min_wrap  = sec_wrap && (t.min == 8'h59);
    hour_wrap = min_wrap && (t.hour == 8'h23);
    date_wrap = hour_wrap && (t.date == last_day(t.month, t.year));
    mon_wrap  = date_wrap && (t.month == 8'h12);
    year_wrap = mon_wrap && (t.year == 8'h99);
    nxt = t;
    nxt.sec = sec_wrap ? 8'h00 : bcd_inc(t.sec);
    if (sec_wrap)  nxt.min   = min_wrap ? 8'h00 : bcd_inc(t.min);
    if (min_wrap)  nxt.hour  = hour_wrap ? 8'h00 : bcd_inc(t.hour);
    if (hour_wrap) begin
      nxt.wday = (t.wday == 8'h06) ? 8'h00 : t.wday + 8'h01;
      nxt.date = date_wrap ? 8'h01 : bcd_inc(t.date);
    end
    if (date_wrap) nxt.month = mon_wrap ? 8'h01 : bcd_inc(t.month);
    if (mon_wrap)  nxt.year  = year_wrap ? 8'h00 : bcd_inc(t.year);
    if (year_wrap) nxt.century = ~t.century;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t       <= '0;
      t.date  <= 8'h01;
      t.month <= 8'h01;
    end else if (time_wr) begin
      case (wr_addr_i)
        A_SEC:   t.sec  <= wr_data_i & 8'h7f;
        A_MIN:   t.min  <= wr_data_i & 8'h7f;
        A_HOUR:  t.hour <= wr_data_i & 8'h3f;
        A_WDAY:  t.wday <= wr_data_i & 8'h07;
        A_DATE:  t.date <= wr_data_i & 8'h3f;
        A_MONTH: begin
          t.month   <= wr_data_i & 8'h1f;
          t.century <= wr_data_i[7];
        end
        default: t.year <= wr_data_i;
      endcase
    end else if (tick_i) begin
      t <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || osc_fail_i)           osf_o <= 1'b1;
    else if (wr_en_i && wr_addr_i == A_SEC) osf_o <= wr_data_i[7];
  end

  assign time_o = t;

  a_r1_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_wr && t.sec == 8'h59) |=> (t.sec == 8'h00));
  a_r4_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_wr && year_wrap) |=> (t.century != $past(t.century)));
  a_r5_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !time_wr) |=> $stable(t));
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (osf_o && !(wr_en_i && wr_addr_i == A_SEC && !wr_data_i[7])) |=> osf_o);
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_MIN) |=> (t.min == ($past(wr_data_i) & 8'h7f)));
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        date_i,
  input  logic [7:0]        wday_i,
  output logic [7:0]        amin_o,
  output logic [7:0]        ahour_o,
  output logic [7:0]        adate_o,
  output logic [7:0]        awday_o,
  output logic              flag_o
);
  logic [3:0] en, eq;
  logic match, match_q, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amin_o  <= 8'h80;
      ahour_o <= 8'h80;
      adate_o <= 8'h80;
      awday_o <= 8'h80;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_AMIN:  amin_o  <= wr_data_i;
        A_AHOUR: ahour_o <= wr_data_i & 8'hbf;
        A_ADATE: adate_o <= wr_data_i & 8'hbf;
        A_AWDAY: awday_o <= wr_data_i & 8'h87;
        default: ;
      endcase
    end
  end

  assign en = {~awday_o[7], ~adate_o[7], ~ahour_o[7], ~amin_o[7]};
  assign eq = {({5'd0, awday_o[2:0]} == wday_i),
               ({2'd0, adate_o[5:0]} == date_i),
               ({2'd0, ahour_o[5:0]} == hour_i),
               ({1'b0, amin_o[6:0]}  == min_i)};
  assign match = (|en) && ((eq | ~en) == 4'hf);
  assign clr   = wr_en_i && (wr_addr_i == A_CTRL) && !wr_data_i[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      match_q <= match;
      if (match && !match_q) flag_o <= 1'b1;
      else if (clr)          flag_o <= 1'b0;
    end
  end

  a_r8_set_on_new_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(match) && !$past(match_q)));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr) |=> flag_o);
  a_r8_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 4'h0 && !flag_o) |=> !flag_o);
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick64_i,
  input  logic              osc_fail_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_irq_o
);
  logic      halt, aie, tick, osf, aflag;
  rtc_time_t tm;
  logic [7:0] amin, ahour, adate, awday;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt <= 1'b0;
      aie  <= 1'b0;
    end else if (wr_en_i && wr_addr_i == A_CTRL) begin
      halt <= wr_data_i[0];
      aie  <= wr_data_i[1];
    end
  end

  rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .strobe_i(tick64_i), .halt_i(halt), .tick_o(tick)
  );

  rtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .osc_fail_i(osc_fail_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .time_o(tm), .osf_o(osf)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .min_i(tm.min), .hour_i(tm.hour), .date_i(tm.date), .wday_i(tm.wday),
    .amin_o(amin), .ahour_o(ahour), .adate_o(adate), .awday_o(awday),
    .flag_o(aflag)
  );

  always_comb begin
    case (rd_addr_i)
      A_CTRL:  rd_data_o = {5'd0, aflag, aie, halt};
      A_SEC:   rd_data_o = {osf, tm.sec[6:0]};
      A_MIN:   rd_data_o = tm.min;
      A_HOUR:  rd_data_o = tm.hour;
      A_WDAY:  rd_data_o = tm.wday;
      A_DATE:  rd_data_o = tm.date;
      A_MONTH: rd_data_o = {tm.century, tm.month[6:0]};
      A_YEAR:  rd_data_o = tm.year;
      A_AMIN:  rd_data_o = amin;
      A_AHOUR: rd_data_o = ahour;
      A_ADATE: rd_data_o = adate;
      A_AWDAY: rd_data_o = awday;
      default: rd_data_o = '0;
    endcase
  end

  assign alarm_irq_o = aflag && aie;

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CTRL && !wr_data_i[1]) |=> !alarm_irq_o);
endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick64 = 1'b0;
  logic       osc_fail = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       alarm_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_calendar_core u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick64_i(tick64), .osc_fail_i(osc_fail),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .alarm_irq_o(alarm_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick64 = 1'b1;
      @(negedge clk); tick64 = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // halted load of a full time, then release: next tick on 32nd strobe
  task automatic set_time(input logic [7:0] base, input int s, m, h, w, d, mo, c, y);
    wr(0, base | 8'h01);
    wr(1, bcd(s)); wr(2, bcd(m)); wr(3, bcd(h)); wr(4, bcd(w));
    wr(5, bcd(d)); wr(6, bcd(mo) | (c ? 8'h80 : 8'h00)); wr(7, bcd(y));
    wr(0, base);
  endtask

  task automatic check_time(input string tag, input int s, m, h, w, d, mo, c, y);
    rchk({tag, " R1 sec"}, 1, bcd(s));
    rchk({tag, " R1 min"}, 2, bcd(m));
    rchk({tag, " R1 hour"}, 3, bcd(h));
    rchk({tag, " R2 wday"}, 4, bcd(w));
    rchk({tag, " R3 date"}, 5, bcd(d));
    rchk({tag, " R4 month"}, 6, bcd(mo) | (c ? 8'h80 : 8'h00));
    rchk({tag, " R4 year"}, 7, bcd(y));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, m, h, w, d, mo, c, y;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state and unused addresses
    rchk("R12 ctrl", 0, 8'h00);
    rchk("R12/R7 seconds", 1, 8'h80);
    rchk("R12 minutes", 2, 8'h00);
    rchk("R12 date", 5, 8'h01);
    rchk("R12 month", 6, 8'h01);
    for (int a = 8; a < 12; a++) rchk("R12 alarm", 4'(a), 8'h80);
    rchk("R12 unused", 14, 8'h00);
    chk("R10 irq at reset", {7'd0, alarm_irq}, 8'h00);

    // R5/R6 prescaler from reset phase
    strobe(31); rchk("R6 before 32nd strobe", 1, 8'h80);
    strobe(1);  rchk("R6 on 32nd strobe", 1, 8'h81);
    strobe(63); rchk("R5 before 64th", 1, 8'h81);
    strobe(1);  rchk("R5 on 64th", 1, 8'h82);
    wr(0, 8'h05);
    strobe(100); rchk("R5 halted", 1, 8'h82);
    wr(0, 8'h04);
    strobe(31); rchk("R6 release 31", 1, 8'h82);
    strobe(1);  rchk("R6 release 32", 1, 8'h83);
    strobe(63); rchk("R6 then 63", 1, 8'h83);
    strobe(1);  rchk("R6 then 64", 1, 8'h84);

    // R7 oscillator-fail flag
    wr(1, 8'h10); rchk("R7 cleared by write 0", 1, 8'h10);
    @(negedge clk); osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
    rchk("R7 set by input", 1, 8'h90);
    wr(1, 8'h90); rchk("R7 write 1 keeps", 1, 8'h90);
    wr(1, 8'h20); rchk("R7 cleared again", 1, 8'h20);

    // R1..R4 full rollover with century
    set_time(8'h04, 59, 59, 23, 6, 31, 12, 0, 99);
    strobe(32);
    check_time("rollover", 0, 0, 0, 0, 1, 1, 1, 0);
    // R3 leap rule
    set_time(8'h04, 59, 59, 23, 2, 28, 2, 1, 24);
    strobe(32);
    rchk("R3 leap Feb 29", 5, 8'h29); rchk("R3 leap month", 6, 8'h82);
    set_time(8'h04, 59, 59, 23, 2, 28, 2, 0, 10);
    strobe(32);
    rchk("R3 year 10 not leap", 5, 8'h01); rchk("R3 March", 6, 8'h03);
    set_time(8'h04, 59, 59, 23, 2, 30, 4, 0, 23);
    strobe(32);
    rchk("R3 April 30 end", 5, 8'h01); rchk("R3 May", 6, 8'h05);

    // random checks against bench model
    for (int k = 0; k < 30; k++) begin
      s  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      m  = ($urandom % 2 != 0) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2 != 0) ? 23 : int'($urandom % 24);
      w  = int'($urandom % 7);
      mo = 1 + int'($urandom % 12);
      y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      c  = int'($urandom % 2);
      d  = ($urandom % 2 != 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      set_time(8'h04, s, m, h, w, d, mo, c, y);
      strobe(32);
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) begin
        h = 0; w = (w + 1) % 7; d++;
        if (d > dim(mo, y)) begin
          d = 1; mo++;
          if (mo == 13) begin
            mo = 1; y++;
            if (y == 100) begin y = 0; c = 1 - c; end
          end
        end
      end
      check_time("random", s, m, h, w, d, mo, c, y);
    end

    // R11 write wins over a coinciding tick
    set_time(8'h04, 30, 20, 10, 1, 5, 5, 0, 5);
    strobe(31);
    @(negedge clk); tick64 = 1'b1; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h45;
    @(negedge clk); tick64 = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rchk("R11 tick dropped", 1, 8'h30);
    rchk("R11 minute written", 2, 8'h45);
    strobe(63); rchk("R11 next tick not early", 1, 8'h30);
    strobe(1);  rchk("R11 next tick on 64th", 1, 8'h31);

    // R8..R10 alarm
    wr(8, 8'h35); wr(9, 8'h12); wr(10, 8'h80); wr(11, 8'h85);
    set_time(8'h06, 59, 34, 12, 3, 15, 6, 0, 21);
    rchk("R8 no match yet", 0, 8'h02);
    strobe(32);
    rchk("R8 flag set on match", 0, 8'h06);
    chk("R10 irq on", {7'd0, alarm_irq}, 8'h01);
    wr(0, 8'h06); rchk("R9 write 1 keeps", 0, 8'h06);
    wr(0, 8'h02); rchk("R9 cleared", 0, 8'h02);
    chk("R10 irq off after clear", {7'd0, alarm_irq}, 8'h00);
    strobe(64); rchk("R9 no reset while matching", 0, 8'h02);
    wr(0, 8'h04); rchk("R10 aie off", 0, 8'h00);
    wr(8, 8'h36); wr(1, 8'h59);
    strobe(64);
    rchk("R8 flag with aie off", 0, 8'h04);
    chk("R10 irq masked", {7'd0, alarm_irq}, 8'h00);
    wr(0, 8'h06);
    chk("R10 irq unmasked", {7'd0, alarm_irq}, 8'h01);
    wr(0, 8'h02);
    wr(9, 8'h13); wr(8, 8'h37); wr(1, 8'h59);
    strobe(64);
    rchk("R8 hour mismatch", 0, 8'h02);
    rchk("R1 minute 37", 2, 8'h37);
    wr(8, 8'h80); wr(9, 8'h80); wr(1, 8'h59);
    strobe(64);
    rchk("R8 nothing enabled", 0, 8'h02);

    // R12 unused address write ignored
    wr(13, 8'hff);
    rchk("R12 unused reads 0", 13, 8'h00);
    rchk("R12 ctrl untouched", 0, 8'h02);
    rchk("R12 minute untouched", 2, 8'h38);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule